// File: doc/BRIEF.md
# Selectable 22 kHz Tone Modulator

This block produces the digital form of the 22 kHz signalling tone that an analog stage superimposes on an antenna supply rail. A one-cycle clock-enable pulse at twenty times the tone rate drives an internal divider, so the tone period is exactly `DIV` enable ticks. Two control bits choose how the tone reaches the output. In continuous mode the tone runs without a break. In envelope mode a synchronous external input gates the internal tone. In pass mode that same input is forwarded unchanged as an already modulated tone.

The block has two outputs for the injection stage. `tone_en` tells the stage to follow `tone_lvl`, and `tone_lvl` is the square wave itself. In envelope mode the tone stays on for a hold window after each rising edge of the external input. This lets a chain of short pulses run as one unbroken burst. A separate combinational output selects the tone detector threshold. It goes to the transmit setting when either a pin or a register bit asks for it.

Top module: `tone_mod`

## Requirements
- R1: With the tone running, consecutive rising edges of `tone_lvl` are exactly `DIV` enable ticks apart (20 ticks by default).
- R2: The internal tone is high for exactly `DIV/2` ticks of each period, so over any whole number of periods `tone_lvl` is high half of the clock cycles.
- R3: When `cont_en`=1 the tone runs continuously with `tone_en`=1, whatever `ext_mod` and `ext_sel` are. `cont_en` has priority over `ext_sel`.
- R4: When `cont_en`=0 and `ext_sel`=0 (envelope mode), the internal tone reaches `tone_lvl` while `ext_mod` is high. Once `ext_mod` is low and the hold window has run out, `tone_en` drops on the next clock edge.
- R5: In envelope mode every rising edge of `ext_mod` keeps the tone enabled for `DIV`+`HOLD_MARGIN` ticks. That is longer than one tone period. After the window the output returns to idle (`tone_en`=0, `tone_lvl`=0). Rising edges closer together than the window give one unbroken burst.
- R6: When `cont_en`=0 and `ext_sel`=1 (pass mode), `tone_en`=1 and `tone_lvl` equals `ext_mod` delayed by one clock.
- R7: `thr_sel` = `txt_pin` OR `thr_bit` at all times, combinationally.
- R8: The divider is held at phase zero while the internal tone is off. The first `tone_lvl` value after the internal tone is enabled is therefore 1.
- R9: During and directly after reset, `tone_en`=0 and `tone_lvl`=0.
- R10: Whenever `tone_en`=0, `tone_lvl`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick | input | 1 | One-cycle enable at 20x the tone rate |
| cont_en | input | 1 | Continuous internal tone request |
| ext_sel | input | 1 | 1: pass the external modulated tone; 0: use `ext_mod` as an envelope |
| ext_mod | input | 1 | External envelope or modulated tone, already synchronous to `clk` |
| txt_pin | input | 1 | Transmit indication from a pin |
| thr_bit | input | 1 | Transmit-threshold request from a register bit |
| tone_en | output | 1 | Injection stage should follow `tone_lvl` |
| tone_lvl | output | 1 | Digital tone level |
| thr_sel | output | 1 | Detector threshold select, 1 = transmit threshold |

## Verification
A divider that holds a wrong count shows up at `tone_lvl` within one tone period. It appears as an unequal high/low split or as a rising-edge spacing other than `DIV` ticks. A hold counter that loads or decrements wrongly shows up as a burst that ends early or never ends, measured in clocks from a single `ext_mod` pulse. A phase that is not cleared between bursts shows up in the first cycle after enable, where `tone_lvl` must be 1.

// File: rtl/tone_mod_pkg.sv
package tone_mod_pkg;

  typedef enum logic [1:0] {
    MODE_CONT = 2'd0,
    MODE_ENV  = 2'd1,
    MODE_PASS = 2'd2
  } tone_mode_e;

  function automatic tone_mode_e decode_mode(input logic cont, input logic sel);
    if (cont)     return MODE_CONT;
    else if (sel) return MODE_PASS;
    else          return MODE_ENV;
  endfunction

endpackage

// File: rtl/tone_divider.sv
module tone_divider #(
  parameter int DIV = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run,
  output logic phase_hi
);
  localparam int W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);
  localparam logic [W-1:0] HALF = W'(DIV / 2);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)
      cnt_d = '0;
    else if (tick)
      cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign phase_hi = run && (cnt_q < HALF);

endmodule

// File: rtl/extm_hold.sv
module extm_hold #(
  parameter int HOLD = 22
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic ext_mod,
  output logic active
);
  localparam int W = $clog2(HOLD + 1);
  localparam logic [W-1:0] LOAD = W'(HOLD);

  logic         prev_q;
  logic [W-1:0] hold_q, hold_d;
  logic         rise;

  assign rise = ext_mod && !prev_q;

  always_comb begin
    hold_d = hold_q;
    if (rise)
      hold_d = LOAD;
    else if (tick && (hold_q != '0))
      hold_d = hold_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      hold_q <= '0;
    end else begin
      prev_q <= ext_mod;
      hold_q <= hold_d;
    end
  end

  assign active = ext_mod || (hold_q != '0);

endmodule

// File: rtl/tone_mod.sv
module tone_mod
  import tone_mod_pkg::*;
#(
  parameter int DIV         = 20,
  parameter int HOLD_MARGIN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic cont_en,
  input  logic ext_sel,
  input  logic ext_mod,
  input  logic txt_pin,
  input  logic thr_bit,
  output logic tone_en,
  output logic tone_lvl,
  output logic thr_sel
);
  localparam int HOLD = DIV + HOLD_MARGIN;

  tone_mode_e mode;
  logic       env_active;
  logic       run;
  logic       phase_hi;
  logic       en_d, lvl_d;
  logic       en_q, lvl_q;

  assign mode = decode_mode(cont_en, ext_sel);

  extm_hold #(.HOLD(HOLD)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .ext_mod(ext_mod),
    .active (env_active)
  );

  assign run = (mode == MODE_CONT) || ((mode == MODE_ENV) && env_active);

  tone_divider #(.DIV(DIV)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .run     (run),
    .phase_hi(phase_hi)
  );

  always_comb begin
    unique case (mode)
      MODE_PASS: begin
        en_d  = 1'b1;
        lvl_d = ext_mod;
      end
      MODE_ENV: begin
        en_d  = env_active;
        lvl_d = phase_hi;
      end
      default: begin
        en_d  = 1'b1;
        lvl_d = phase_hi;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      lvl_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      lvl_q <= lvl_d;
    end
  end

  assign tone_en  = en_q;
  assign tone_lvl = lvl_q;
  assign thr_sel  = txt_pin | thr_bit;

endmodule

// File: rtl/tone_mod_chk.sv
module tone_mod_chk (
  input logic clk,
  input logic rst_n,
  input logic cont_en,
  input logic ext_sel,
  input logic ext_mod,
  input logic txt_pin,
  input logic thr_bit,
  input logic tone_en,
  input logic tone_lvl,
  input logic thr_sel
);

  p_thr_or_r7: assert property (@(posedge clk) disable iff (!rst_n)
    thr_sel == (txt_pin | thr_bit));

  p_cont_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(cont_en) |-> tone_en);

  p_pass_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(!cont_en && ext_sel) |-> (tone_en && tone_lvl == $past(ext_mod)));

  p_idle_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !tone_en |-> !tone_lvl);

  p_burst_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tone_en) && $past(cont_en || !ext_sel) |-> tone_lvl);

  p_end_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tone_en) |-> $past(!ext_mod && !cont_en && !ext_sel));

endmodule

bind tone_mod tone_mod_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cont_en (cont_en),
  .ext_sel (ext_sel),
  .ext_mod (ext_mod),
  .txt_pin (txt_pin),
  .thr_bit (thr_bit),
  .tone_en (tone_en),
  .tone_lvl(tone_lvl),
  .thr_sel (thr_sel)
);

// File: tb/tone_mod_bench.sv
`timescale 1ns/1ps
module tone_mod_bench;
  localparam int DIV    = 20;
  localparam int MARGIN = 2;
  localparam int HOLD   = DIV + MARGIN;
  localparam int TP     = 4;
  localparam int PER    = DIV * TP;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic cont_en = 1'b0, ext_sel = 1'b0, ext_mod = 1'b0, txt_pin = 1'b0, thr_bit = 1'b0;
  logic tone_en, tone_lvl, thr_sel;
  int   tc = 0;
  int   total = 0;
  int   bad = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  always @(negedge clk) begin
    tick <= (tc == TP - 1);
    tc   <= (tc == TP - 1) ? 0 : tc + 1;
  end

  tone_mod #(.DIV(DIV), .HOLD_MARGIN(MARGIN)) u_tone_mod (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cont_en(cont_en), .ext_sel(ext_sel),
    .ext_mod(ext_mod), .txt_pin(txt_pin), .thr_bit(thr_bit),
    .tone_en(tone_en), .tone_lvl(tone_lvl), .thr_sel(thr_sel)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic count_high(input int n, input bit toggle_ext, output int hi, output int rises,
                            output int gap);
    int last_rise;
    bit prev;
    hi = 0; rises = 0; gap = -1; last_rise = -1;
    prev = tone_lvl;
    for (int i = 0; i < n; i++) begin
      if (toggle_ext) ext_mod = (i % 7) < 3;
      @(negedge clk);
      if (tone_lvl) hi++;
      if (tone_lvl && !prev) begin
        if (last_rise >= 0) gap = i - last_rise;
        last_rise = i;
        rises++;
      end
      prev = tone_lvl;
    end
  endtask

  initial begin
    #2_000_000;
    total++;
    bad++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_run();
  end

  initial begin
    int hi, rises, gap, len;
    bit prev_ext, ok_all;
    step(3);
    chk(tone_en == 1'b0 && tone_lvl == 1'b0, "R9 in reset", int'({tone_en, tone_lvl}), 0);
    rst_n = 1'b1;
    step(2);
    chk(tone_en == 1'b0 && tone_lvl == 1'b0, "R9 after reset", int'({tone_en, tone_lvl}), 0);

    // R7: threshold select, all four input combinations
    for (int k = 0; k < 4; k++) begin
      txt_pin = k[0]; thr_bit = k[1];
      #1;
      chk(thr_sel == (k[0] | k[1]), "R7 thr_sel", int'(thr_sel), int'(k[0] | k[1]));
    end
    txt_pin = 0; thr_bit = 0;

    // R10: envelope mode, idle input, no tone
    step(PER * 2);
    ok_all = 1'b1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (tone_en || tone_lvl) ok_all = 1'b0;
    end
    chk(ok_all, "R10 idle envelope", int'(ok_all), 1);

    // R3/R8: continuous tone starts high
    cont_en = 1'b1;
    step(1);
    chk(tone_lvl == 1'b1 && tone_en == 1'b1, "R8 cont first level", int'({tone_en, tone_lvl}), 3);
    step(PER);
    count_high(5 * PER, 1'b1, hi, rises, gap);
    chk(hi == 5 * PER / 2, "R2 cont duty with ext toggling", hi, 5 * PER / 2);
    chk(gap == PER, "R1 period", gap, PER);
    chk(rises >= 4, "R1 rise count", rises, 5);

    // R3: cont has priority over pass select
    ext_sel = 1'b1;
    count_high(5 * PER, 1'b1, hi, rises, gap);
    chk(hi == 5 * PER / 2, "R3 cont over pass duty", hi, 5 * PER / 2);
    chk(gap == PER, "R3 cont over pass period", gap, PER);
    cont_en = 1'b0; ext_sel = 1'b0; ext_mod = 1'b0;
    step(PER * 2);
    chk(tone_en == 1'b0 && tone_lvl == 1'b0, "R10 after cont off", int'({tone_en, tone_lvl}), 0);

    // R4/R8: envelope high for ten periods
    ext_mod = 1'b1;
    step(1);
    chk(tone_lvl == 1'b1 && tone_en == 1'b1, "R8 envelope first level", int'({tone_en, tone_lvl}), 3);
    count_high(10 * PER, 1'b0, hi, rises, gap);
    chk(hi >= 10 * PER / 2 - TP && hi <= 10 * PER / 2 + TP, "R4 envelope duty", hi, 10 * PER / 2);
    chk(gap == PER, "R1 envelope period", gap, PER);
    ext_mod = 1'b0;
    step(2);
    chk(tone_en == 1'b0 && tone_lvl == 1'b0, "R4 envelope stop", int'({tone_en, tone_lvl}), 0);

    // R5: single short pulse holds tone for the window
    step(PER);
    ext_mod = 1'b1;
    step(1);
    ext_mod = 1'b0;
    len = 1;
    while (tone_en && len < 10 * PER) begin
      @(negedge clk);
      if (tone_en) len++;
    end
    chk(len >= (HOLD - 1) * TP && len <= HOLD * TP + 1, "R5 hold length", len, HOLD * TP);
    chk(len > PER, "R5 hold exceeds one period", len, PER + 1);
    chk(tone_lvl == 1'b0, "R5 idle level after hold", int'(tone_lvl), 0);

    // R5: retriggered pulses keep one burst
    ok_all = 1'b1;
    for (int p = 0; p < 10; p++) begin
      ext_mod = 1'b1;
      @(negedge clk);
      if (!tone_en) ok_all = 1'b0;
      ext_mod = 1'b0;
      for (int i = 0; i < 10 * TP - 1; i++) begin
        @(negedge clk);
        if (!tone_en) ok_all = 1'b0;
      end
    end
    chk(ok_all, "R5 retrigger continuous", int'(ok_all), 1);
    step(HOLD * TP + 2 * TP);
    chk(tone_en == 1'b0, "R5 retrigger ends", int'(tone_en), 0);

    // R6: pass-through with one clock delay
    ext_sel = 1'b1;
    step(1);
    prev_ext = ext_mod;
    ok_all = 1'b1;
    for (int i = 0; i < 300; i++) begin
      ext_mod = ((i * 7 + i / 5) % 3) == 0;
      @(negedge clk);
      if (tone_lvl != ext_mod || !tone_en) begin
        ok_all = 1'b0;
        $display("FAIL R6 pass actual=%0d expected=%0d", tone_lvl, ext_mod);
      end
      prev_ext = ext_mod;
    end
    total++;
    if (!ok_all) bad++;
    ext_sel = 1'b0; ext_mod = 1'b0;
    step(HOLD * TP + 2 * TP);
    chk(tone_en == 1'b0 && tone_lvl == 1'b0, "R10 after pass", int'({tone_en, tone_lvl}), 0);

    finish_run();
  end

endmodule